// File: doc/BRIEF.md
# Per-Core Ordered Store Buffer

This block sits between one core's load/store port and a single shared memory port. Stores are accepted into an eight-entry queue and written to memory one at a time, in the order the core issued them. Loads are handled one at a time. The order they keep relative to buffered stores is set by a run-time mode. In the strict mode, a load waits until every older store has left the queue. In the relaxed mode, a load may go ahead of older stores to other addresses. A load in the relaxed mode that hits a queued address takes its value from the youngest matching store, and memory is not read.

The memory port carries both kinds of request on one valid/ready handshake. A write needs no response. A read returns its data on a one-cycle response strobe. A fence pulse holds off new traffic until the queue has fully drained, and then raises a one-cycle completion flag. A change of mode is latched only while the queue is empty, so loads never mix orderings with the stores already in flight.

Top module: `store_order_buf`

## Requirements
- R1: A store is accepted (stReady high) while fewer than 8 stores are queued. With 8 queued, stReady is low and no store enters.
- R2: Queued stores are presented on the memory port as writes (memReqWrite=1) in the order they were accepted, at most one per cycle, each with the address and data it was accepted with.
- R3: A memory request that is presented and not accepted keeps memReqValid, memReqWrite, memReqAddr and, for writes, memReqData unchanged in the next cycle.
- R4: In strict mode (modeTso=0), a load's read request reaches memory only after every store accepted before it has been written, even when the addresses differ.
- R5: In relaxed mode (modeTso=1), a load whose address matches no queued store is sent to memory at the next free memory slot, ahead of queued stores still waiting.
- R6: In relaxed mode, a load whose address matches one or more queued stores returns the data of the youngest matching store, and issues no memory read.
- R7: The mode input is latched only in cycles when the queue is empty. A change made while stores are queued takes effect after they drain.
- R8: A one-cycle fenceReq blocks new loads and stores (ldReady and stReady low) until the queue is empty. fenceDone is then high for exactly one cycle, by which time every earlier store has been written.
- R9: A load response holds rspValid and rspData until rspReady is seen high. For a memory-served load, rspData equals the read data.
- R10: After reset the queue is empty, stReady and ldReady are high, and memReqValid, rspValid and fenceDone are low.
- R11: A store accepted in the same cycle as a load counts as younger than that load and is never forwarded to it. While an accepted load waits to issue its read, stReady is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeTso | input | 1 | Requested ordering mode: 0 strict, 1 relaxed |
| fenceReq | input | 1 | Fence request pulse |
| fenceDone | output | 1 | One-cycle flag when a fence has drained the queue |
| stValid | input | 1 | Store request valid |
| stReady | output | 1 | Store request ready |
| stAddr | input | 16 | Store address |
| stData | input | 32 | Store data |
| ldValid | input | 1 | Load request valid |
| ldReady | output | 1 | Load request ready |
| ldAddr | input | 16 | Load address |
| rspValid | output | 1 | Load response valid |
| rspReady | input | 1 | Load response ready |
| rspData | output | 32 | Load response data |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory request accepted |
| memReqWrite | output | 1 | 1 for write, 0 for read |
| memReqAddr | output | 16 | Memory request address |
| memReqData | output | 32 | Write data (zero for reads) |
| memRspValid | input | 1 | Read data strobe |
| memRspData | input | 32 | Read data |

## Verification
Two functions can fall in the same cycle: a store entering the queue and a load being accepted that looks up the same address. The bench drives both requests valid together, with a different store to that address already queued, and requires the load to return the older queued value rather than the one arriving alongside it. It also confirms that both writes then reach memory in order. A second collision is a queued store leaving for memory while a relaxed-mode load competes for the same port. This is provoked by stalling memory with two stores queued, then releasing it, and it is judged by the number of writes the memory model has logged when the read arrives.

// File: rtl/sob_pkg.sv
package sob_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic push;        // store accepted into the queue
    logic pop;         // head store accepted by memory
    logic ldCapture;   // latch load address
    logic fwdCapture;  // latch forwarded store data as response
    logic memCapture;  // latch memory read data as response
  } sobStrobes_t;

  typedef enum logic [1:0] {
    LD_IDLE,
    LD_WAIT,
    LD_READ,
    LD_OUT
  } ldState_t;

  typedef enum logic [1:0] {
    OWN_NONE,
    OWN_LOAD,
    OWN_STORE
  } memOwner_t;

endpackage

// File: rtl/sob_datapath.sv
module sob_datapath
  import sob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  sobStrobes_t       strobes,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [DATA_W-1:0] stData,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [DATA_W-1:0] memRspData,
  output logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] headAddr,
  output logic [DATA_W-1:0] headData,
  output logic              fwdHit,
  output logic [DATA_W-1:0] fwdData,
  output logic [ADDR_W-1:0] ldAddrQ,
  output logic [DATA_W-1:0] rspData
);

  logic [ADDR_W-1:0] entAddr [DEPTH];
  logic [DATA_W-1:0] entData [DEPTH];
  logic [PTR_W-1:0]  head, tail;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strobes.push) begin
      entAddr[tail] <= stAddr;
      entData[tail] <= stData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (strobes.push) tail <= nextPtr(tail);
      if (strobes.pop)  head <= nextPtr(head);
      case ({strobes.push, strobes.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headAddr = entAddr[head];
  assign headData = entData[head];

  // Age-ordered search from head; a younger match overrides an older one.
  always_comb begin
    int slot;
    fwdHit  = 1'b0;
    fwdData = '0;
    for (int age = 0; age < DEPTH; age++) begin
      slot = int'(head) + age;
      if (slot >= DEPTH) slot = slot - DEPTH;
      if (CNT_W'(age) < count && entAddr[slot] == ldAddr) begin
        fwdHit  = 1'b1;
        fwdData = entData[slot];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ldAddrQ <= '0;
      rspData <= '0;
    end else begin
      if (strobes.ldCapture)  ldAddrQ <= ldAddr;
      if (strobes.fwdCapture) rspData <= fwdData;
      if (strobes.memCapture) rspData <= memRspData;
    end
  end

  // R1: control never pushes into a full queue
  assert_push_not_full_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.push && !strobes.pop |-> count < CNT_W'(DEPTH));

  // R2: control never pops an empty queue
  assert_pop_not_empty_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pop |-> count != '0);

endmodule

// File: rtl/sob_control.sv
module sob_control
  import sob_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeTso,
  input  logic             fenceReq,
  input  logic             stValid,
  input  logic             ldValid,
  input  logic             rspReady,
  input  logic             memReqReady,
  input  logic             memRspValid,
  input  logic [CNT_W-1:0] count,
  input  logic             fwdHit,
  output logic             stReady,
  output logic             ldReady,
  output logic             rspValid,
  output logic             fenceDone,
  output logic             memReqValid,
  output logic             memReqWrite,
  output sobStrobes_t      strobes
);

  ldState_t  ldState;
  memOwner_t owner;
  logic      effTso, ldTsoQ, fencing;
  logic      empty, full, ldAccept, stAccept, ldForward;
  logic      loadEligible, grantLoad, grantStore, memAccept;

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));

  assign ldReady  = (ldState == LD_IDLE) && !fencing;
  assign stReady  = !full && !fencing && (ldState != LD_WAIT);
  assign ldAccept = ldValid && ldReady;
  assign stAccept = stValid && stReady;
  assign ldForward = ldAccept && effTso && fwdHit;

  // Strict loads wait for an empty queue; relaxed loads go when the port is free.
  assign loadEligible = (ldState == LD_WAIT) && (ldTsoQ || empty);
  assign grantLoad  = (owner == OWN_LOAD)  || (owner == OWN_NONE && loadEligible);
  assign grantStore = (owner == OWN_STORE) || (owner == OWN_NONE && !loadEligible && !empty);
  assign memReqValid = grantLoad || grantStore;
  assign memReqWrite = grantStore;
  assign memAccept   = memReqValid && memReqReady;

  assign rspValid = (ldState == LD_OUT);

  always_comb begin
    strobes            = '0;
    strobes.push       = stAccept;
    strobes.pop        = memAccept && grantStore;
    strobes.ldCapture  = ldAccept;
    strobes.fwdCapture = ldForward;
    strobes.memCapture = (ldState == LD_READ) && memRspValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      owner <= OWN_NONE;
    end else if (memReqValid && !memReqReady) begin
      owner <= grantLoad ? OWN_LOAD : OWN_STORE;
    end else begin
      owner <= OWN_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ldState <= LD_IDLE;
      ldTsoQ  <= 1'b0;
    end else begin
      if (ldAccept) ldTsoQ <= effTso;
      case (ldState)
        LD_IDLE: if (ldAccept) ldState <= ldForward ? LD_OUT : LD_WAIT;
        LD_WAIT: if (grantLoad && memReqReady) ldState <= LD_READ;
        LD_READ: if (memRspValid) ldState <= LD_OUT;
        LD_OUT:  if (rspReady) ldState <= LD_IDLE;
        default: ldState <= LD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      effTso    <= 1'b0;
      fencing   <= 1'b0;
      fenceDone <= 1'b0;
    end else begin
      if (empty) effTso <= modeTso;
      fenceDone <= fencing && empty;
      if (fenceReq)              fencing <= 1'b1;
      else if (fencing && empty) fencing <= 1'b0;
    end
  end

  // R3: a stalled request keeps its kind
  assert_req_kind_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqWrite));

  // R4: a strict-mode read goes out only with an empty queue
  assert_strict_read_empty_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqWrite && !ldTsoQ |-> empty);

  // R6: a forwarded load answers in the next cycle
  assert_forward_answers_R6: assert property (@(posedge clk) disable iff (!rstN)
    ldForward |=> rspValid);

  // R8: completion flag lasts one cycle and only with an empty queue
  assert_fence_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    fenceDone |=> !fenceDone);
  assert_fence_empty_R8: assert property (@(posedge clk) disable iff (!rstN)
    fenceDone |-> empty);

  // R9: response held until taken
  assert_resp_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid);

endmodule

// File: rtl/store_order_buf.sv
module store_order_buf
  import sob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeTso,
  input  logic              fenceReq,
  output logic              fenceDone,
  input  logic              stValid,
  output logic              stReady,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [DATA_W-1:0] stData,
  input  logic              ldValid,
  output logic              ldReady,
  input  logic [ADDR_W-1:0] ldAddr,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [DATA_W-1:0] rspData,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [DATA_W-1:0] memReqData,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  sobStrobes_t       strobes;
  logic [CNT_W-1:0]  count;
  logic [ADDR_W-1:0] headAddr, ldAddrQ;
  logic [DATA_W-1:0] headData, fwdData;
  logic              fwdHit;

  sob_control #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .modeTso(modeTso), .fenceReq(fenceReq),
    .stValid(stValid), .ldValid(ldValid), .rspReady(rspReady),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .count(count), .fwdHit(fwdHit),
    .stReady(stReady), .ldReady(ldReady), .rspValid(rspValid),
    .fenceDone(fenceDone), .memReqValid(memReqValid),
    .memReqWrite(memReqWrite), .strobes(strobes)
  );

  sob_datapath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .stAddr(stAddr), .stData(stData), .ldAddr(ldAddr),
    .memRspData(memRspData), .count(count),
    .headAddr(headAddr), .headData(headData),
    .fwdHit(fwdHit), .fwdData(fwdData),
    .ldAddrQ(ldAddrQ), .rspData(rspData)
  );

  assign memReqAddr = memReqWrite ? headAddr : ldAddrQ;
  assign memReqData = memReqWrite ? headData : '0;

  // R3: stalled request payload stays put
  assert_req_payload_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> $stable(memReqAddr) && $stable(memReqData));

  // R9: response data stays put while waiting
  assert_resp_data_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> $stable(rspData));

endmodule

// File: tb/store_order_buf_test.sv
module store_order_buf_test;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;

  logic clk = 0, rstN = 0;
  logic modeTso = 0, fenceReq = 0, fenceDone;
  logic stValid = 0, stReady;
  logic [ADDR_W-1:0] stAddr = '0;
  logic [DATA_W-1:0] stData = '0;
  logic ldValid = 0, ldReady;
  logic [ADDR_W-1:0] ldAddr = '0;
  logic rspValid, rspReady = 0;
  logic [DATA_W-1:0] rspData;
  logic memReqValid, memReady = 0, memReqWrite;
  logic [ADDR_W-1:0] memReqAddr;
  logic [DATA_W-1:0] memReqData;
  logic memRspValid = 0;
  logic [DATA_W-1:0] memRspData = '0;

  int checks = 0, errors = 0;
  int writeCount = 0, readCount = 0, lastReadPos = -1;
  logic [ADDR_W-1:0] logAddr [64];
  logic [DATA_W-1:0] logData [64];
  logic [DATA_W-1:0] memArr  [64];
  logic rdPend = 0;
  logic [DATA_W-1:0] rdDataQ = '0;

  always #4 clk = ~clk;

  store_order_buf uut (
    .clk(clk), .rstN(rstN), .modeTso(modeTso), .fenceReq(fenceReq),
    .fenceDone(fenceDone), .stValid(stValid), .stReady(stReady),
    .stAddr(stAddr), .stData(stData), .ldValid(ldValid), .ldReady(ldReady),
    .ldAddr(ldAddr), .rspValid(rspValid), .rspReady(rspReady),
    .rspData(rspData), .memReqValid(memReqValid), .memReqReady(memReady),
    .memReqWrite(memReqWrite), .memReqAddr(memReqAddr),
    .memReqData(memReqData), .memRspValid(memRspValid),
    .memRspData(memRspData)
  );

  // Memory model: evaluated mid-cycle, mirrors the handshake at the next edge.
  always @(negedge clk) begin
    memRspValid = rdPend;
    memRspData  = rdDataQ;
    rdPend      = 1'b0;
    if (rstN && memReqValid && memReady) begin
      if (memReqWrite) begin
        if (writeCount < 64) begin
          logAddr[writeCount] = memReqAddr;
          logData[writeCount] = memReqData;
        end
        memArr[memReqAddr[5:0]] = memReqData;
        writeCount++;
      end else begin
        rdDataQ     = memArr[memReqAddr[5:0]];
        rdPend      = 1'b1;
        lastReadPos = writeCount;
        readCount++;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic pushStore(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    logic ok;
    stValid = 1; stAddr = a; stData = d;
    forever begin
      ok = stReady;
      tick(1);
      if (ok) break;
    end
    stValid = 0;
  endtask

  task automatic issueLoad(input logic [ADDR_W-1:0] a);
    logic ok;
    ldValid = 1; ldAddr = a;
    forever begin
      ok = ldReady;
      tick(1);
      if (ok) break;
    end
    ldValid = 0;
  endtask

  task automatic takeResp(input logic [DATA_W-1:0] exp, input string tag);
    rspReady = 1;
    while (!rspValid) tick(1);
    chk(tag, rspData, exp);
    tick(1);
    rspReady = 0;
  endtask

  task automatic waitWrites(input int n);
    while (writeCount < n) tick(1);
  endtask

  task automatic testReset();
    chk("R10 stReady", stReady, 1);
    chk("R10 ldReady", ldReady, 1);
    chk("R10 memReqValid", memReqValid, 0);
    chk("R10 rspValid", rspValid, 0);
    chk("R10 fenceDone", fenceDone, 0);
  endtask

  task automatic testFillDrain();
    int base = writeCount;
    memReady = 0;
    for (int i = 0; i < 8; i++) pushStore(16'h10 + 16'(i), 32'h100 + 32'(i));
    chk("R1 full blocks store", stReady, 0);
    chk("R3 write presented", {memReqValid, memReqWrite}, 2'b11);
    chk("R3 head address", memReqAddr, 16'h10);
    tick(3);
    chk("R3 address held", memReqAddr, 16'h10);
    chk("R3 data held", memReqData, 32'h100);
    memReady = 1;
    waitWrites(base + 8);
    for (int i = 0; i < 8; i++) begin
      chk("R2 write order addr", logAddr[base + i], 16'h10 + 16'(i));
      chk("R2 write order data", logData[base + i], 32'h100 + 32'(i));
    end
    tick(1);
    chk("R1 ready after drain", stReady, 1);
  endtask

  task automatic testStrictOrder();
    int base = writeCount;
    logic [DATA_W-1:0] held;
    memReady = 0;
    pushStore(16'h01, 32'h11);
    pushStore(16'h02, 32'h22);
    issueLoad(16'h30);
    chk("R11 store blocked while load waits", stReady, 0);
    tick(2);
    chk("R4 only writes while stores queued", {memReqValid, memReqWrite}, 2'b11);
    memReady = 1;
    while (!rspValid) tick(1);
    chk("R4 read after both writes", lastReadPos, base + 2);
    held = rspData;
    tick(2);
    chk("R9 rspValid held", rspValid, 1);
    chk("R9 rspData held", rspData, held);
    takeResp(32'hA000_0030, "R9 read data");
  endtask

  task automatic testRelaxedPass();
    int base;
    modeTso = 1;
    tick(2);
    base = writeCount;
    memReady = 0;
    pushStore(16'h03, 32'h33);
    pushStore(16'h04, 32'h44);
    issueLoad(16'h31);
    memReady = 1;
    takeResp(32'hA000_0031, "R5 read data");
    waitWrites(base + 2);
    chk("R5 read passes second store", lastReadPos, base + 1);
  endtask

  task automatic testForward();
    int rd = readCount;
    int base = writeCount;
    memReady = 0;
    pushStore(16'h05, 32'h111);
    pushStore(16'h06, 32'h222);
    pushStore(16'h05, 32'h333);
    issueLoad(16'h05);
    takeResp(32'h333, "R6 youngest match");
    chk("R6 no memory read", readCount, rd);
    memReady = 1;
    waitWrites(base + 3);
    chk("R2 last write data", logData[base + 2], 32'h333);
  endtask

  task automatic testSameCycle();
    int base = writeCount;
    logic both;
    memReady = 0;
    pushStore(16'h07, 32'h444);
    stValid = 1; stAddr = 16'h07; stData = 32'h555;
    ldValid = 1; ldAddr = 16'h07;
    both = stReady && ldReady;
    tick(1);
    stValid = 0; ldValid = 0;
    chk("R11 both accepted", both, 1);
    takeResp(32'h444, "R11 same-cycle store not forwarded");
    memReady = 1;
    waitWrites(base + 2);
    chk("R11 older write first", logData[base], 32'h444);
    chk("R11 younger write second", logData[base + 1], 32'h555);
  endtask

  task automatic testModeDefer();
    int base = writeCount;
    memReady = 0;
    pushStore(16'h08, 32'h88);
    modeTso = 0;
    pushStore(16'h09, 32'h99);
    issueLoad(16'h32);
    memReady = 1;
    takeResp(32'hA000_0032, "R7 read data");
    waitWrites(base + 2);
    chk("R7 relaxed order kept while queued", lastReadPos, base + 1);
    tick(2);
    base = writeCount;
    memReady = 0;
    pushStore(16'h0A, 32'hAA);
    pushStore(16'h0B, 32'hBB);
    issueLoad(16'h33);
    memReady = 1;
    takeResp(32'hA000_0033, "R7 read data strict");
    chk("R7 strict order after drain", lastReadPos, base + 2);
  endtask

  task automatic testFence();
    int base = writeCount;
    int pulses = 0, atDone = -1;
    memReady = 0;
    pushStore(16'h0C, 32'hCC);
    pushStore(16'h0D, 32'hDD);
    fenceReq = 1;
    tick(1);
    fenceReq = 0;
    chk("R8 loads blocked", ldReady, 0);
    chk("R8 stores blocked", stReady, 0);
    chk("R8 no early done", fenceDone, 0);
    memReady = 1;
    for (int i = 0; i < 20; i++) begin
      if (fenceDone) begin
        pulses++;
        if (atDone < 0) atDone = writeCount;
      end
      tick(1);
    end
    chk("R8 single done pulse", pulses, 1);
    chk("R8 writes done at flag", atDone, base + 2);
    chk("R8 loads reopened", ldReady, 1);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) memArr[i] = 32'hA000_0000 + 32'(i);
    tick(3);
    rstN = 1;
    tick(1);
    testReset();
    testFillDrain();
    testStrictOrder();
    testRelaxedPass();
    testForward();
    testSameCycle();
    testModeDefer();
    testFence();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule